// File: doc/BRIEF.md
# Multi-Hit Match Selector

A ternary CAM that scans a byte stream reports one matching address per cycle, namely the entry with the highest priority. Shorter patterns that sit inside a longer matching entry are hidden from that single result. This block takes the one reported hit and turns it, in the same cycle, into up to K related pattern entries. Each entry comes from a bank of host-writable expansion registers indexed by the hit address. Every expanded entry is tagged as either a short pattern or a head subpattern of a long pattern.

A short pattern is reported at once. Its pattern ID goes into one of K parallel result slots, together with the byte position of the hit. A head subpattern claims an idle tracking element from a pool of NUM_PE elements, chosen lowest index first. The element is then started with the pattern ID of the long pattern it will follow. If several long patterns share a head, each one gets its own expansion slot and its own element. An element hands itself back by pulsing its done line. When a head finds no idle element, a sticky overflow flag is raised.

Top module: `multihit_selector`

## Requirements
- R1: After reset, every expansion entry holds the invalid code (all ones). All elements are idle, the overflow flag is low, and no result slot or start pulse is active. A hit on any address therefore yields nothing.
- R2: While cam_hit is low, the next cycle shows no result slot valid, no start pulse, and exp_addr at the invalid code in every slot, whatever cam_addr holds.
- R3: A hit whose slot j is live and of kind short (kind bit 0) sets rep_vld[j] one cycle later. rep_pid slot j then carries that entry's pattern ID, and rep_pos carries the byte_pos sampled with the hit. The ID field is 0 when the slot is not valid, and rep_pos is 0 when no slot is valid.
- R4: One cycle after a hit, exp_addr slot j shows the related address stored in slot j of the hit address's entry. A slot that holds the invalid code produces neither a report nor an allocation.
- R5: Live slots of kind head (kind bit 1) claim idle elements, lowest element index first. Lower slots claim lower-indexed elements. One cycle after the hit, pe_start pulses for each claimed element, and pe_pid field i carries the pattern ID given to element i (0 otherwise).
- R6: Several head slots in one entry, which stands for long patterns that share a head, start distinct elements in the same cycle.
- R7: A started element shows in pe_busy from the cycle of its start pulse. It stays busy until a cycle with its pe_done bit high. pe_done on an idle element has no effect.
- R8: An element that is claimed while its pe_done bit is high in the same cycle still pulses pe_start, but shows as idle on the following cycle.
- R9: A head slot that finds no idle element is dropped and sets alloc_overflow. The flag stays set until reset.
- R10: A configuration write takes effect at the next edge. A hit in the same cycle as the write still uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Expansion register write strobe |
| cfg_addr | input | ADDR_W | CAM address whose entry is written |
| cfg_slot | input | SLOT_W | Slot within the entry (writes to slots >= K are ignored) |
| cfg_kind | input | 1 | Slot kind: 0 short pattern, 1 head subpattern |
| cfg_rel | input | ADDR_W | Related address; all ones marks the slot unused |
| cfg_pid | input | PID_W | Pattern ID for the slot |
| cam_hit | input | 1 | CAM hit qualifier |
| cam_addr | input | ADDR_W | Reported CAM hit address |
| byte_pos | input | POS_W | Stream byte position of the current window |
| pe_done | input | NUM_PE | Release request from each tracking element |
| rep_vld | output | K | Short-pattern result valid per slot |
| rep_pid | output | K*PID_W | Short-pattern IDs, slot j in bits [j*PID_W +: PID_W] |
| rep_pos | output | POS_W | Byte position of the reported hit |
| exp_addr | output | K*ADDR_W | Expanded related addresses per slot |
| pe_start | output | NUM_PE | Start pulse per tracking element |
| pe_pid | output | NUM_PE*PID_W | Pattern ID handed to each started element |
| pe_busy | output | NUM_PE | Busy state of each element |
| alloc_overflow | output | 1 | Sticky allocation overflow flag |

## Verification
Directed cases cover an empty table right after reset, to separate invalid slots from real entries. Entries are then loaded with a mix of short and head kinds, and the addresses are probed with the qualifier low and then high, to separate gating from lookup. One entry holds three heads, which shows one element per shared head against a single grant. A claim that coincides with a release shows which of the two wins the busy bit. A table write and a hit in the same cycle show old data against new. The pool is then driven until it runs dry, to show that a dropped allocation sets the sticky flag. A long random run with a fixed seed mixes hits, rewrites and releases, so that partial pools with holes exercise the lowest-index order.

// File: rtl/mhs_pkg.sv
package mhs_pkg;
  typedef enum logic {
    KIND_SHORT = 1'b0,
    KIND_HEAD  = 1'b1
  } mhs_kind_e;

  // returns the lowest set bit of a vector as a one-hot value
  function automatic logic [63:0] lowest_onehot(input logic [63:0] v);
    return v & (~v + 64'd1);
  endfunction
endpackage

// File: rtl/mhs_expand_table.sv
module mhs_expand_table #(
  parameter int ADDR_W = 4,
  parameter int K      = 3,
  parameter int PID_W  = 8,
  parameter int SLOT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [SLOT_W-1:0]     cfg_slot,
  input  logic                  cfg_kind,
  input  logic [ADDR_W-1:0]     cfg_rel,
  input  logic [PID_W-1:0]      cfg_pid,
  input  logic [ADDR_W-1:0]     hit_addr,
  output logic [K*ADDR_W-1:0]   slot_rel,
  output logic [K-1:0]          slot_kind,
  output logic [K*PID_W-1:0]    slot_pid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] INV = '1;

  logic [ADDR_W-1:0] rel_q  [DEPTH][K];
  logic              kind_q [DEPTH][K];
  logic [PID_W-1:0]  pid_q  [DEPTH][K];

  logic wr_ok;
  assign wr_ok = cfg_we && (int'(cfg_slot) < K);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) begin
        for (int s = 0; s < K; s++) begin
          rel_q[a][s]  <= INV;
          kind_q[a][s] <= 1'b0;
          pid_q[a][s]  <= '0;
        end
      end
    end else if (wr_ok) begin
      for (int s = 0; s < K; s++) begin
        if (int'(cfg_slot) == s) begin
          rel_q[cfg_addr][s]  <= cfg_rel;
          kind_q[cfg_addr][s] <= cfg_kind;
          pid_q[cfg_addr][s]  <= cfg_pid;
        end
      end
    end
  end

  for (genvar s = 0; s < K; s++) begin : g_mux
    assign slot_rel[s*ADDR_W +: ADDR_W] = rel_q[hit_addr][s];
    assign slot_kind[s]                 = kind_q[hit_addr][s];
    assign slot_pid[s*PID_W +: PID_W]   = pid_q[hit_addr][s];
  end
endmodule

// File: rtl/mhs_classify.sv
module mhs_classify #(
  parameter int ADDR_W = 4,
  parameter int K      = 3
) (
  input  logic                cam_hit,
  input  logic [K*ADDR_W-1:0] slot_rel,
  input  logic [K-1:0]        slot_kind,
  output logic [K-1:0]        short_req,
  output logic [K-1:0]        head_req
);
  localparam logic [ADDR_W-1:0] INV = '1;

  function automatic logic slot_live(input logic [ADDR_W-1:0] rel);
    return rel != INV;
  endfunction

  for (genvar j = 0; j < K; j++) begin : g_cls
    logic live;
    assign live         = cam_hit && slot_live(slot_rel[j*ADDR_W +: ADDR_W]);
    assign short_req[j] = live && (slot_kind[j] == mhs_pkg::KIND_SHORT);
    assign head_req[j]  = live && (slot_kind[j] == mhs_pkg::KIND_HEAD);
  end
endmodule

// File: rtl/mhs_pe_alloc.sv
module mhs_pe_alloc #(
  parameter int K      = 3,
  parameter int NUM_PE = 4,
  parameter int PID_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [K-1:0]            head_req,
  input  logic [K*PID_W-1:0]      head_pid,
  input  logic [NUM_PE-1:0]       pe_done,
  output logic [NUM_PE-1:0]       alloc_vec,
  output logic [NUM_PE*PID_W-1:0] alloc_pid,
  output logic [NUM_PE-1:0]       busy_q,
  output logic                    miss
);
  logic [NUM_PE-1:0] avail [K+1];
  logic [NUM_PE-1:0] grant [K];
  logic [K-1:0]      miss_j;

  assign avail[0] = ~busy_q;

  for (genvar j = 0; j < K; j++) begin : g_chain
    logic [63:0] pick;
    assign pick       = mhs_pkg::lowest_onehot(64'(avail[j]));
    assign grant[j]   = head_req[j] ? pick[NUM_PE-1:0] : '0;
    assign avail[j+1] = avail[j] & ~grant[j];
    assign miss_j[j]  = head_req[j] && (avail[j] == '0);
  end

  always_comb begin
    alloc_vec = '0;
    alloc_pid = '0;
    for (int j = 0; j < K; j++) begin
      alloc_vec = alloc_vec | grant[j];
      for (int i = 0; i < NUM_PE; i++) begin
        if (grant[j][i]) alloc_pid[i*PID_W +: PID_W] = head_pid[j*PID_W +: PID_W];
      end
    end
  end

  assign miss = |miss_j;

  // release wins over a same-cycle claim
  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q | alloc_vec) & ~pe_done;
  end

  for (genvar i = 0; i < NUM_PE; i++) begin : g_hold
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[i] && !pe_done[i]) |=> busy_q[i]);
  end
endmodule

// File: rtl/multihit_selector.sv
module multihit_selector #(
  parameter int ADDR_W = 4,
  parameter int K      = 3,
  parameter int PID_W  = 8,
  parameter int POS_W  = 16,
  parameter int NUM_PE = 4,
  localparam int SLOT_W = (K > 1) ? $clog2(K) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [SLOT_W-1:0]       cfg_slot,
  input  logic                    cfg_kind,
  input  logic [ADDR_W-1:0]       cfg_rel,
  input  logic [PID_W-1:0]        cfg_pid,
  input  logic                    cam_hit,
  input  logic [ADDR_W-1:0]       cam_addr,
  input  logic [POS_W-1:0]        byte_pos,
  input  logic [NUM_PE-1:0]       pe_done,
  output logic [K-1:0]            rep_vld,
  output logic [K*PID_W-1:0]      rep_pid,
  output logic [POS_W-1:0]        rep_pos,
  output logic [K*ADDR_W-1:0]     exp_addr,
  output logic [NUM_PE-1:0]       pe_start,
  output logic [NUM_PE*PID_W-1:0] pe_pid,
  output logic [NUM_PE-1:0]       pe_busy,
  output logic                    alloc_overflow
);
  localparam logic [ADDR_W-1:0] INV = '1;

  logic [K*ADDR_W-1:0]     slot_rel;
  logic [K-1:0]            slot_kind;
  logic [K*PID_W-1:0]      slot_pid;
  logic [K-1:0]            short_req;
  logic [K-1:0]            head_req;
  logic [NUM_PE-1:0]       alloc_vec;
  logic [NUM_PE*PID_W-1:0] alloc_pid;
  logic                    alloc_miss;
  logic [K*PID_W-1:0]      short_pid;

  mhs_expand_table #(.ADDR_W(ADDR_W), .K(K), .PID_W(PID_W), .SLOT_W(SLOT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_slot(cfg_slot),
    .cfg_kind(cfg_kind), .cfg_rel(cfg_rel), .cfg_pid(cfg_pid), .hit_addr(cam_addr),
    .slot_rel(slot_rel), .slot_kind(slot_kind), .slot_pid(slot_pid)
  );

  mhs_classify #(.ADDR_W(ADDR_W), .K(K)) u_cls (
    .cam_hit(cam_hit), .slot_rel(slot_rel), .slot_kind(slot_kind),
    .short_req(short_req), .head_req(head_req)
  );

  mhs_pe_alloc #(.K(K), .NUM_PE(NUM_PE), .PID_W(PID_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .head_req(head_req), .head_pid(slot_pid), .pe_done(pe_done),
    .alloc_vec(alloc_vec), .alloc_pid(alloc_pid), .busy_q(pe_busy), .miss(alloc_miss)
  );

  for (genvar j = 0; j < K; j++) begin : g_spid
    assign short_pid[j*PID_W +: PID_W] = short_req[j] ? slot_pid[j*PID_W +: PID_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_vld        <= '0;
      rep_pid        <= '0;
      rep_pos        <= '0;
      exp_addr       <= {K{INV}};
      pe_start       <= '0;
      pe_pid         <= '0;
      alloc_overflow <= 1'b0;
    end else begin
      rep_vld        <= short_req;
      rep_pid        <= short_pid;
      rep_pos        <= (|short_req) ? byte_pos : '0;
      exp_addr       <= cam_hit ? slot_rel : {K{INV}};
      pe_start       <= alloc_vec;
      pe_pid         <= alloc_pid;
      alloc_overflow <= alloc_overflow | alloc_miss;
    end
  end

  // R2
  no_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cam_hit |=> (rep_vld == '0 && pe_start == '0));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_overflow |=> alloc_overflow);

  // R5
  start_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pe_start) |-> ((pe_start & $past(pe_busy)) == '0));

  // R6
  start_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pe_start) <= K);

  for (genvar j = 0; j < K; j++) begin : g_slot_chk
    // R4
    valid_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rep_vld[j] |-> (exp_addr[j*ADDR_W +: ADDR_W] != INV));
  end
endmodule

// File: tb/multihit_selector_tb.sv
module multihit_selector_tb;
  localparam int ADDR_W = 4;
  localparam int K      = 3;
  localparam int PID_W  = 8;
  localparam int POS_W  = 16;
  localparam int NUM_PE = 4;
  localparam int SLOT_W = 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] INV = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [SLOT_W-1:0] cfg_slot = '0;
  logic cfg_kind = 1'b0;
  logic [ADDR_W-1:0] cfg_rel = '0;
  logic [PID_W-1:0] cfg_pid = '0;
  logic cam_hit = 1'b0;
  logic [ADDR_W-1:0] cam_addr = '0;
  logic [POS_W-1:0] byte_pos = '0;
  logic [NUM_PE-1:0] pe_done = '0;
  logic [K-1:0] rep_vld;
  logic [K*PID_W-1:0] rep_pid;
  logic [POS_W-1:0] rep_pos;
  logic [K*ADDR_W-1:0] exp_addr;
  logic [NUM_PE-1:0] pe_start;
  logic [NUM_PE*PID_W-1:0] pe_pid;
  logic [NUM_PE-1:0] pe_busy;
  logic alloc_overflow;

  always #2.5 clk = ~clk;

  multihit_selector #(.ADDR_W(ADDR_W), .K(K), .PID_W(PID_W), .POS_W(POS_W), .NUM_PE(NUM_PE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_slot(cfg_slot),
    .cfg_kind(cfg_kind), .cfg_rel(cfg_rel), .cfg_pid(cfg_pid), .cam_hit(cam_hit),
    .cam_addr(cam_addr), .byte_pos(byte_pos), .pe_done(pe_done), .rep_vld(rep_vld),
    .rep_pid(rep_pid), .rep_pos(rep_pos), .exp_addr(exp_addr), .pe_start(pe_start),
    .pe_pid(pe_pid), .pe_busy(pe_busy), .alloc_overflow(alloc_overflow)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  // reference model state
  logic [ADDR_W-1:0] m_rel  [DEPTH][K];
  logic              m_kind [DEPTH][K];
  logic [PID_W-1:0]  m_pid  [DEPTH][K];
  logic [NUM_PE-1:0] m_busy;
  logic              m_ovf;

  logic [K-1:0]            e_vld;
  logic [K*PID_W-1:0]      e_rpid;
  logic [POS_W-1:0]        e_pos;
  logic [K*ADDR_W-1:0]     e_addr;
  logic [NUM_PE-1:0]       e_start;
  logic [NUM_PE*PID_W-1:0] e_ppid;

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < DEPTH; a++)
      for (int s = 0; s < K; s++) begin
        m_rel[a][s] = INV; m_kind[a][s] = 1'b0; m_pid[a][s] = '0;
      end
    m_busy = '0; m_ovf = 1'b0;
  endtask

  // computes expectations for the inputs now driven, then advances the model
  task automatic model_step();
    logic [NUM_PE-1:0] avail;
    bit found;
    avail = ~m_busy;
    e_vld = '0; e_rpid = '0; e_pos = '0; e_addr = {K{INV}}; e_start = '0; e_ppid = '0;
    if (cam_hit) begin
      for (int j = 0; j < K; j++) begin
        e_addr[j*ADDR_W +: ADDR_W] = m_rel[cam_addr][j];
        if (m_rel[cam_addr][j] != INV) begin
          if (m_kind[cam_addr][j] == 1'b0) begin
            e_vld[j] = 1'b1;
            e_rpid[j*PID_W +: PID_W] = m_pid[cam_addr][j];
          end else begin
            found = 0;
            for (int i = 0; i < NUM_PE; i++) begin
              if (!found && avail[i]) begin
                found = 1; avail[i] = 1'b0; e_start[i] = 1'b1;
                e_ppid[i*PID_W +: PID_W] = m_pid[cam_addr][j];
              end
            end
            if (!found) m_ovf = 1'b1;
          end
        end
      end
    end
    if (e_vld != '0) e_pos = byte_pos;
    m_busy = (m_busy | e_start) & ~pe_done;
    if (cfg_we && int'(cfg_slot) < K) begin
      m_rel[cfg_addr][cfg_slot] = cfg_rel;
      m_kind[cfg_addr][cfg_slot] = cfg_kind;
      m_pid[cfg_addr][cfg_slot] = cfg_pid;
    end
  endtask

  task automatic compare_all();
    check("R3", "rep_vld", 64'(rep_vld), 64'(e_vld));
    check("R3", "rep_pid", 64'(rep_pid), 64'(e_rpid));
    check("R3", "rep_pos", 64'(rep_pos), 64'(e_pos));
    check("R4", "exp_addr", 64'(exp_addr), 64'(e_addr));
    check("R5", "pe_start", 64'(pe_start), 64'(e_start));
    check("R5", "pe_pid", 64'(pe_pid), 64'(e_ppid));
    check("R7", "pe_busy", 64'(pe_busy), 64'(m_busy));
    check("R9", "alloc_overflow", 64'(alloc_overflow), 64'(m_ovf));
  endtask

  // drive at a falling edge, clock once, sample at the next falling edge
  task automatic cyc(input logic hit, input logic [ADDR_W-1:0] a, input logic [POS_W-1:0] pos,
                     input logic [NUM_PE-1:0] done);
    cam_hit = hit; cam_addr = a; byte_pos = pos; pe_done = done;
    model_step();
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; cam_hit = 1'b0; pe_done = '0;
    compare_all();
  endtask

  task automatic cfg_set(input logic [ADDR_W-1:0] a, input int s, input logic kind,
                         input logic [ADDR_W-1:0] rel, input logic [PID_W-1:0] pid);
    cfg_we = 1'b1; cfg_addr = a; cfg_slot = SLOT_W'(s); cfg_kind = kind; cfg_rel = rel; cfg_pid = pid;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of outputs
    check("R1", "rep_vld", 64'(rep_vld), 64'd0);
    check("R1", "exp_addr", 64'(exp_addr), 64'(e_addr_inv()));
    check("R1", "pe_busy", 64'(pe_busy), 64'd0);
    check("R1", "alloc_overflow", 64'(alloc_overflow), 64'd0);
    // R1: empty table gives nothing on any address
    for (int a = 0; a < DEPTH; a++) begin
      cyc(1'b1, ADDR_W'(a), 16'(a), '0);
      check("R1", "empty rep_vld", 64'(rep_vld), 64'd0);
      check("R1", "empty pe_start", 64'(pe_start), 64'd0);
    end

    // load entries: addr 2 = short,short,head ; addr 5 = three heads (R6)
    cfg_set(4'd2, 0, 1'b0, 4'd2, 8'h21); cyc(1'b0, '0, '0, '0);
    cfg_set(4'd2, 1, 1'b0, 4'd7, 8'h22); cyc(1'b0, '0, '0, '0);
    cfg_set(4'd2, 2, 1'b1, 4'd2, 8'h23); cyc(1'b0, '0, '0, '0);
    cfg_set(4'd5, 0, 1'b1, 4'd5, 8'h51); cyc(1'b0, '0, '0, '0);
    cfg_set(4'd5, 1, 1'b1, 4'd5, 8'h52); cyc(1'b0, '0, '0, '0);
    cfg_set(4'd5, 2, 1'b1, 4'd5, 8'h53); cyc(1'b0, '0, '0, '0);
    // slot index 3 is out of range: ignored (R10)
    cfg_set(4'd2, 3, 1'b0, 4'd1, 8'hEE); cyc(1'b0, '0, '0, '0);

    // R2: qualifier low on a populated address
    cyc(1'b0, 4'd2, 16'h0100, '0);
    check("R2", "no-hit rep_vld", 64'(rep_vld), 64'd0);
    check("R2", "no-hit pe_start", 64'(pe_start), 64'd0);
    check("R2", "no-hit exp_addr", 64'(exp_addr), 64'(e_addr_inv()));

    // R3: two shorts reported with position, one head allocated
    cyc(1'b1, 4'd2, 16'h1234, '0);
    check("R3", "short slots", 64'(rep_vld), 64'b011);
    check("R3", "position", 64'(rep_pos), 64'h1234);
    check("R5", "head to PE0", 64'(pe_start), 64'b0001);

    // R6: shared head starts three distinct elements (PE1..PE3)
    cyc(1'b1, 4'd5, 16'h0200, '0);
    check("R6", "three starts", 64'(pe_start), 64'b1110);
    check("R6", "pid of PE3", 64'(pe_pid[3*PID_W +: PID_W]), 64'h53);

    // R9: pool exhausted, head dropped and flag set
    cyc(1'b1, 4'd2, 16'h0300, '0);
    check("R9", "dropped start", 64'(pe_start), 64'd0);
    check("R9", "overflow set", 64'(alloc_overflow), 64'd1);

    // R7: release PE1 and PE2, then lowest idle is PE1
    cyc(1'b0, '0, '0, 4'b0110);
    check("R7", "busy after release", 64'(pe_busy), 64'b1001);
    cyc(1'b1, 4'd2, 16'h0400, '0);
    check("R5", "lowest idle PE1", 64'(pe_start), 64'b0010);
    check("R9", "overflow sticky", 64'(alloc_overflow), 64'd1);

    // R8: claim of PE2 with its done high in the same cycle
    cyc(1'b1, 4'd2, 16'h0500, 4'b0100);
    check("R8", "start pulse", 64'(pe_start), 64'b0100);
    check("R8", "idle next cycle", 64'(pe_busy), 64'b1011);

    // R10: write and hit in one cycle use the old entry
    cfg_set(4'd2, 0, 1'b0, INV, 8'h00);
    cyc(1'b1, 4'd2, 16'h0600, 4'b1111);
    check("R10", "old entry used", 64'(rep_vld), 64'b011);
    cyc(1'b1, 4'd2, 16'h0700, '0);
    check("R10", "new entry used", 64'(rep_vld), 64'b010);
    check("R4", "invalid slot code", 64'(exp_addr[ADDR_W-1:0]), 64'(INV));

    // constrained random run
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 100) < 8) begin
        cfg_set(ADDR_W'($urandom), int'($urandom % 4), 1'($urandom),
                (($urandom % 4) == 0) ? INV : ADDR_W'($urandom), PID_W'($urandom));
      end
      cyc((($urandom % 100) < 60), ADDR_W'($urandom), POS_W'($urandom),
          NUM_PE'($urandom) & NUM_PE'($urandom));
    end

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [K*ADDR_W-1:0] e_addr_inv();
    return {K{INV}};
  endfunction
endmodule